// File: doc/BRIEF.md
# External Chip-Select Controller

This block sits between an internal bus master and the external memory bus. For each accepted access it decides which of eight external chip selects, if any, owns the address. It then drives that select, the read/write direction line and four byte strobes, and holds them for the programmed number of wait states. A one-clock transfer-done pulse ends the access. Each select is set up through a simple configuration write port with an enable bit, a base address, an address mask, a port-size code, a burst-capable flag, a wait-state count and an SDRAM flag.

Out of reset, select 0 is the only live select and answers every address, so a boot memory can be read before software sets anything up. Requests can also be marked as on-chip targets. In that case no chip select fires, and the strobes follow the rules for on-chip peripheral or on-chip memory accesses.

Top module: `ext_cs_ctrl`

## Requirements
- R1: `cs_n_o` has NCS active-low bits. At most one of them is low in any cycle. Each select keeps its own enable, base, mask, wait count (0 to 15), port code and burst flag, loaded together when `cfg_we_i` is high and `cfg_sel_i` names the select.
- R2: After reset, select 0 is enabled with mask all zeros, base zero, BOOT_WAIT wait states, port code 2 and burst flag 0, so it matches every external address. Every other select is disabled. All outputs are idle: `cs_n_o` all ones, `bs_o` = 4'hF, `oe_rd_o` = 1, `done_o` = 0.
- R3: A disabled select never asserts, even when its base and mask match. Once it is written with the enable bit set, it asserts for matching addresses.
- R4: An external access (`req_tgt_i` = 0) matches select k when k is enabled and (addr & mask_k) == (base_k & mask_k). When several selects match, the lowest index drives its chip select.
- R5: The SDRAM flag is stored only for the highest select (index NCS-1). A configuration write that sets it for any other select leaves that select's strobes at SRAM polarity.
- R6: `oe_rd_o` is 0 during a read access (`req_we_i` = 0), 1 during a write access, and 1 when idle.
- R7: Lanes are chosen from the address offset a = addr[1:0] and `req_size_i` (0 byte, 1 word, 2 or 3 longword), with lane 3 the most significant byte. A byte uses lane 3-a. A word uses lanes 3,2 when a[1] = 0 and lanes 1,0 when a[1] = 1. A longword uses all four lanes.
- R8: For an SRAM-type select, used lanes are driven 0 and unused lanes 1. For the top select with its SDRAM flag set, used lanes are driven 1 and unused lanes 0.
- R9: On-chip peripheral accesses (`req_tgt_i` = 1) assert no chip select and drive the used lanes low. On-chip memory accesses (`req_tgt_i` = 2 or 3) assert no chip select and leave all strobes high. Both take zero wait states.
- R10: A request seen in the idle state is taken on that clock edge. From the next cycle the outputs hold for w+1 cycles, where w is the selected wait count. `done_o` is high only in the last of those cycles, and everything returns to idle on the following clock. Requests that arrive during an access are ignored.
- R11: During an access to select k, `burst_o` and `port_o` show select k's burst flag and port code. Otherwise both are 0.
- R12: An external access that matches no enabled select asserts no chip select, keeps `bs_o` at 4'hF, and completes with zero wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | IW | Select being configured |
| cfg_en_i | input | 1 | Enable bit |
| cfg_base_i | input | AW | Base address |
| cfg_mask_i | input | AW | Address mask (1 = compared bit) |
| cfg_wait_i | input | WW | Wait-state count |
| cfg_port_i | input | 2 | Port-size code |
| cfg_burst_i | input | 1 | Burst-capable flag |
| cfg_sdram_i | input | 1 | SDRAM flag (kept for top select only) |
| req_i | input | 1 | Access request |
| req_we_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | AW | Access address |
| req_size_i | input | 2 | 0 byte, 1 word, 2/3 longword |
| req_tgt_i | input | 2 | 0 external, 1 on-chip peripheral, 2/3 on-chip memory |
| cs_n_o | output | NCS | Active-low chip selects |
| oe_rd_o | output | 1 | Direction: 0 read, 1 write |
| bs_o | output | 4 | Byte strobes |
| burst_o | output | 1 | Selected select is burst capable |
| port_o | output | 2 | Selected select's port code |
| done_o | output | 1 | Transfer-done pulse |

## Verification
The bench builds the block with AW = 8 and BOOT_WAIT = 3, which makes the whole address space of 256 locations small enough to sweep. Every address is tried with every size and direction against a map that includes overlapping windows, a disabled window, a gap and an SDRAM window, and again as on-chip peripheral and on-chip memory accesses. The small wait counts keep each access short while still covering the zero-wait case and the multi-cycle case, including a request that arrives in the middle of an access.

// File: rtl/ext_cs_pkg.sv
package ext_cs_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2} acc_size_e;
  typedef enum logic [1:0] {TGT_EXT = 2'd0, TGT_PERIPH = 2'd1, TGT_MEM = 2'd2} acc_tgt_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_ACT = 1'b1} cs_state_e;
  localparam logic [3:0] BS_IDLE = 4'hF;
endpackage

// File: rtl/ext_cs_regs.sv
module ext_cs_regs #(
  parameter int unsigned NCS       = 8,
  parameter int unsigned AW        = 32,
  parameter int unsigned WW        = 4,
  parameter int unsigned BOOT_WAIT = 15,
  localparam int unsigned IW       = $clog2(NCS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IW-1:0]              sel_i,
  input  logic                       en_i,
  input  logic [AW-1:0]              base_i,
  input  logic [AW-1:0]              mask_i,
  input  logic [WW-1:0]              wait_i,
  input  logic [1:0]                 port_i,
  input  logic                       burst_i,
  input  logic                       sdram_i,
  output logic [NCS-1:0]             en_o,
  output logic [NCS-1:0][AW-1:0]     base_o,
  output logic [NCS-1:0][AW-1:0]     mask_o,
  output logic [NCS-1:0][WW-1:0]     wait_o,
  output logic [NCS-1:0][1:0]        port_o,
  output logic [NCS-1:0]             burst_o,
  output logic [NCS-1:0]             sdram_o
);
  for (genvar k = 0; k < NCS; k++) begin : g_sel
    logic hit_wr;
    assign hit_wr = we_i && (sel_i == IW'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[k]    <= (k == 0);
        base_o[k]  <= {AW{1'b0}};
        mask_o[k]  <= (k == 0) ? {AW{1'b0}} : {AW{1'b1}};
        wait_o[k]  <= (k == 0) ? WW'(BOOT_WAIT) : {WW{1'b0}};
        port_o[k]  <= (k == 0) ? 2'd2 : 2'd0;
        burst_o[k] <= 1'b0;
      end else if (hit_wr) begin
        en_o[k]    <= en_i;
        base_o[k]  <= base_i;
        mask_o[k]  <= mask_i;
        wait_o[k]  <= wait_i;
        port_o[k]  <= port_i;
        burst_o[k] <= burst_i;
      end
    end

    // SDRAM mode exists only on the top select
    if (k == NCS - 1) begin : g_sd
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     sdram_o[k] <= 1'b0;
        else if (hit_wr) sdram_o[k] <= sdram_i;
      end
    end else begin : g_nosd
      assign sdram_o[k] = 1'b0;
    end
  end
endmodule

// File: rtl/ext_cs_decode.sv
module ext_cs_decode #(
  parameter int unsigned NCS = 8,
  parameter int unsigned AW  = 32,
  localparam int unsigned IW = $clog2(NCS)
) (
  input  logic [AW-1:0]          addr_i,
  input  logic [NCS-1:0]         en_i,
  input  logic [NCS-1:0][AW-1:0] base_i,
  input  logic [NCS-1:0][AW-1:0] mask_i,
  output logic                   hit_o,
  output logic [IW-1:0]          idx_o
);
  logic [NCS-1:0] match;

  for (genvar k = 0; k < NCS; k++) begin : g_cmp
    assign match[k] = en_i[k] && ((addr_i & mask_i[k]) == (base_i[k] & mask_i[k]));
  end

  // scan downward so the lowest index is written last
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = NCS - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit_o = 1'b1;
        idx_o = IW'(k);
      end
    end
  end
endmodule

// File: rtl/ext_cs_lanes.sv
module ext_cs_lanes (
  input  logic [1:0] off_i,
  input  logic [1:0] size_i,
  output logic [3:0] lanes_o
);
  import ext_cs_pkg::*;

  // lane 3 carries the most significant byte (offset 0)
  always_comb begin
    unique case (size_i)
      SZ_BYTE: lanes_o = 4'b1000 >> off_i;
      SZ_WORD: lanes_o = off_i[1] ? 4'b0011 : 4'b1100;
      default: lanes_o = 4'b1111;
    endcase
  end
endmodule

// File: rtl/ext_cs_ctrl.sv
module ext_cs_ctrl
  import ext_cs_pkg::*;
#(
  parameter int unsigned NCS       = 8,
  parameter int unsigned AW        = 32,
  parameter int unsigned WW        = 4,
  parameter int unsigned BOOT_WAIT = 15,
  localparam int unsigned IW       = $clog2(NCS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [IW-1:0]  cfg_sel_i,
  input  logic           cfg_en_i,
  input  logic [AW-1:0]  cfg_base_i,
  input  logic [AW-1:0]  cfg_mask_i,
  input  logic [WW-1:0]  cfg_wait_i,
  input  logic [1:0]     cfg_port_i,
  input  logic           cfg_burst_i,
  input  logic           cfg_sdram_i,
  input  logic           req_i,
  input  logic           req_we_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [1:0]     req_size_i,
  input  logic [1:0]     req_tgt_i,
  output logic [NCS-1:0] cs_n_o,
  output logic           oe_rd_o,
  output logic [3:0]     bs_o,
  output logic           burst_o,
  output logic [1:0]     port_o,
  output logic           done_o
);
  logic [NCS-1:0]          en_v, burst_v, sdram_v;
  logic [NCS-1:0][AW-1:0]  base_v, mask_v;
  logic [NCS-1:0][WW-1:0]  wait_v;
  logic [NCS-1:0][1:0]     port_v;

  ext_cs_regs #(.NCS(NCS), .AW(AW), .WW(WW), .BOOT_WAIT(BOOT_WAIT)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .en_i(cfg_en_i), .base_i(cfg_base_i),
    .mask_i(cfg_mask_i), .wait_i(cfg_wait_i), .port_i(cfg_port_i),
    .burst_i(cfg_burst_i), .sdram_i(cfg_sdram_i),
    .en_o(en_v), .base_o(base_v), .mask_o(mask_v), .wait_o(wait_v),
    .port_o(port_v), .burst_o(burst_v), .sdram_o(sdram_v)
  );

  logic          hit;
  logic [IW-1:0] idx;

  ext_cs_decode #(.NCS(NCS), .AW(AW)) u_dec (
    .addr_i(req_addr_i), .en_i(en_v), .base_i(base_v), .mask_i(mask_v),
    .hit_o(hit), .idx_o(idx)
  );

  logic [3:0] lanes;

  ext_cs_lanes u_lanes (.off_i(req_addr_i[1:0]), .size_i(req_size_i), .lanes_o(lanes));

  // values the access will present, decided at acceptance
  logic [NCS-1:0] nx_cs_n;
  logic [3:0]     nx_bs;
  logic [WW-1:0]  nx_wait;
  logic           nx_burst;
  logic [1:0]     nx_port;

  always_comb begin
    nx_cs_n  = '1;
    nx_bs    = BS_IDLE;
    nx_wait  = '0;
    nx_burst = 1'b0;
    nx_port  = 2'd0;
    if (req_tgt_i == TGT_EXT && hit) begin
      nx_cs_n[idx] = 1'b0;
      nx_wait      = wait_v[idx];
      nx_burst     = burst_v[idx];
      nx_port      = port_v[idx];
      nx_bs        = sdram_v[idx] ? lanes : ~lanes;
    end else if (req_tgt_i == TGT_PERIPH) begin
      nx_bs = ~lanes;
    end
  end

  cs_state_e     state_q;
  logic [WW-1:0] cnt_q;
  logic          idle;

  assign idle   = (state_q == ST_IDLE);
  assign done_o = (state_q == ST_ACT) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cs_n_o  <= '1;
      bs_o    <= BS_IDLE;
      oe_rd_o <= 1'b1;
      burst_o <= 1'b0;
      port_o  <= 2'd0;
    end else if (idle) begin
      if (req_i) begin
        state_q <= ST_ACT;
        cnt_q   <= nx_wait;
        cs_n_o  <= nx_cs_n;
        bs_o    <= nx_bs;
        oe_rd_o <= req_we_i;
        burst_o <= nx_burst;
        port_o  <= nx_port;
      end
    end else if (cnt_q == '0) begin
      state_q <= ST_IDLE;
      cs_n_o  <= '1;
      bs_o    <= BS_IDLE;
      oe_rd_o <= 1'b1;
      burst_o <= 1'b0;
      port_o  <= 2'd0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ext_cs_ctrl_chk.sv
module ext_cs_ctrl_chk #(
  parameter int unsigned NCS = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic           req_we_i,
  input logic [NCS-1:0] cs_n_o,
  input logic [3:0]     bs_o,
  input logic           oe_rd_o,
  input logic           done_o,
  input logic           idle_i,
  input logic [NCS-1:0] sdram_i
);
  p_cs_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));

  p_sdram_top_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdram_i[NCS-2:0] == '0);

  p_dir_follows_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && req_i) |=> (oe_rd_o == $past(req_we_i)));

  p_release_after_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (&cs_n_o && !done_o && bs_o == 4'hF && oe_rd_o));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> (&cs_n_o && !done_o && bs_o == 4'hF));
endmodule

bind ext_cs_ctrl ext_cs_ctrl_chk #(.NCS(NCS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_we_i(req_we_i),
  .cs_n_o(cs_n_o), .bs_o(bs_o), .oe_rd_o(oe_rd_o), .done_o(done_o),
  .idle_i(idle), .sdram_i(sdram_v)
);

// File: tb/ext_cs_ctrl_bench.sv
module ext_cs_ctrl_bench;
  localparam int NCS = 8;
  localparam int AW  = 8;
  localparam int WW  = 4;
  localparam int BW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic           cfg_we = 0, cfg_en = 0, cfg_burst = 0, cfg_sdram = 0;
  logic [2:0]     cfg_sel = 0;
  logic [AW-1:0]  cfg_base = 0, cfg_mask = 0;
  logic [WW-1:0]  cfg_wait = 0;
  logic [1:0]     cfg_port = 0;
  logic           req = 0, req_we = 0;
  logic [AW-1:0]  req_addr = 0;
  logic [1:0]     req_size = 0, req_tgt = 0;
  logic [NCS-1:0] cs_n;
  logic           oe_rd, burst, done;
  logic [3:0]     bs;
  logic [1:0]     port;

  ext_cs_ctrl #(.NCS(NCS), .AW(AW), .WW(WW), .BOOT_WAIT(BW)) u_ext_cs_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_en_i(cfg_en), .cfg_base_i(cfg_base),
    .cfg_mask_i(cfg_mask), .cfg_wait_i(cfg_wait), .cfg_port_i(cfg_port),
    .cfg_burst_i(cfg_burst), .cfg_sdram_i(cfg_sdram),
    .req_i(req), .req_we_i(req_we), .req_addr_i(req_addr), .req_size_i(req_size),
    .req_tgt_i(req_tgt),
    .cs_n_o(cs_n), .oe_rd_o(oe_rd), .bs_o(bs), .burst_o(burst), .port_o(port),
    .done_o(done)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench's own view of the programmed map
  int m_base[NCS], m_mask[NCS], m_wait[NCS], m_port[NCS];
  bit m_en[NCS], m_sd[NCS], m_burst[NCS];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] lanes_of(input int a, input int s);
    if (s == 0) return 4'b1000 >> (a & 3);
    if (s == 1) return ((a & 2) != 0) ? 4'b0011 : 4'b1100;
    return 4'hF;
  endfunction

  task automatic cfg(input int k, input bit en, input int base, input int mask,
                     input int w, input int p, input bit bu, input bit sd);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(k); cfg_en = en; cfg_base = AW'(base); cfg_mask = AW'(mask);
    cfg_wait = WW'(w); cfg_port = 2'(p); cfg_burst = bu; cfg_sdram = sd;
    @(negedge clk);
    cfg_we = 0;
    m_en[k] = en; m_base[k] = base; m_mask[k] = mask; m_wait[k] = w;
    m_port[k] = p; m_burst[k] = bu;
    m_sd[k] = (k == NCS - 1) ? sd : 1'b0;  // R5: flag kept on top select only
  endtask

  task automatic access(input int a, input int s, input bit we, input int tgt,
                        input string tag, input bit poke);
    int win = -1;
    int w;
    logic [NCS-1:0] e_cs;
    logic [3:0] ln, e_bs;
    bit e_bu;
    int e_pt;
    if (tgt == 0)
      for (int k = NCS - 1; k >= 0; k--)
        if (m_en[k] && ((a & m_mask[k]) == (m_base[k] & m_mask[k]))) win = k;
    ln = lanes_of(a, s);
    e_cs = (win >= 0) ? ~(NCS'(1) << win) : '1;
    w = (win >= 0) ? m_wait[win] : 0;
    e_bu = (win >= 0) ? m_burst[win] : 1'b0;
    e_pt = (win >= 0) ? m_port[win] : 0;
    if (tgt >= 2 || (tgt == 0 && win < 0)) e_bs = 4'hF;
    else if (win >= 0 && m_sd[win]) e_bs = ln;
    else e_bs = ~ln;

    req = 1; req_addr = AW'(a); req_size = 2'(s); req_we = we; req_tgt = 2'(tgt);
    @(negedge clk);
    req = 0;
    for (int i = 0; i <= w; i++) begin
      chk(cs_n == e_cs, {tag, " R4 cs"}, cs_n, e_cs);
      chk(bs == e_bs, {tag, " R7 bs"}, bs, e_bs);
      chk(oe_rd == we, {tag, " R6 oe_rd"}, oe_rd, we);
      chk(burst == e_bu && port == 2'(e_pt), {tag, " R11 attr"}, {burst, port}, {e_bu, 2'(e_pt)});
      chk(done == (i == w), {tag, " R10 done"}, done, (i == w));
      if (poke && i == 0) begin
        req = 1; req_addr = ~AW'(a); req_we = ~we;
      end
      if (i < w) @(negedge clk);
      req = 0;
    end
    @(negedge clk);
    chk(&cs_n && bs == 4'hF && !done && oe_rd, {tag, " R10 release"},
        {cs_n, bs, done, oe_rd}, {8'hFF, 4'hF, 1'b0, 1'b1});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NCS; k++) begin
      m_en[k] = (k == 0); m_base[k] = 0; m_mask[k] = (k == 0) ? 0 : 'hFF;
      m_wait[k] = (k == 0) ? BW : 0; m_port[k] = (k == 0) ? 2 : 0;
      m_burst[k] = 0; m_sd[k] = 0;
    end
    repeat (3) @(negedge clk);
    chk(&cs_n && bs == 4'hF && !done && oe_rd && !burst && port == 0, "R2 reset idle",
        {cs_n, bs, done, oe_rd}, {8'hFF, 4'hF, 1'b0, 1'b1});
    rst_n = 1;
    @(negedge clk);

    // R2: boot select answers everywhere
    access(8'h00, 2, 0, 0, "R2", 0);
    access(8'h5A, 0, 1, 0, "R2", 0);
    access(8'hFF, 1, 0, 0, "R2", 0);

    cfg(0, 1, 'h00, 'hC0, 0, 2, 0, 0);
    cfg(1, 1, 'h40, 'hE0, 1, 1, 0, 0);
    cfg(2, 1, 'h40, 'hC0, 2, 0, 1, 0);
    cfg(3, 1, 'h80, 'hF0, 3, 1, 1, 1);   // SDRAM request ignored
    cfg(4, 0, 'h90, 'hF0, 0, 2, 0, 0);   // disabled window
    cfg(5, 1, 'hA0, 'hE0, 0, 2, 0, 0);
    cfg(7, 1, 'hC0, 'hC0, 1, 3, 1, 1);

    access(8'h95, 0, 0, 0, "R3", 0);
    access(8'h9F, 2, 1, 0, "R12", 0);
    access(8'h83, 0, 1, 0, "R5", 0);
    access(8'hC1, 0, 1, 0, "R8", 0);
    access(8'h41, 1, 0, 0, "R4 overlap", 0);
    access(8'h80, 2, 0, 0, "R10 poke", 1);

    for (int a = 0; a < 256; a++)
      for (int s = 0; s < 3; s++)
        for (int we = 0; we < 2; we++)
          access(a, s, bit'(we), 0, "R1 sweep", 0);

    for (int a = 0; a < 256; a++)
      for (int s = 0; s < 4; s++) begin
        access(a, s, bit'(a & 1), 1, "R9 periph", 0);
        access(a, s, bit'(s & 1), 2 + (a & 1), "R9 mem", 0);
      end

    cfg(4, 1, 'h90, 'hF0, 2, 1, 1, 0);
    access(8'h95, 0, 0, 0, "R3 enabled", 0);
    cfg(7, 1, 'hC0, 'hC0, 0, 3, 0, 0);
    access(8'hC2, 1, 0, 0, "R8 sram", 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule